// File: doc/BRIEF.md
# Fractional-Baud Sync Message Receiver

This block receives a serial sync message on a single line. It does not use a fixed mid-bit oversampling counter. Each capture point is placed by three programmable intervals. A start interval runs from the detected falling edge of the start bit to the first capture. After that, two intervals alternate between captures. Because the two alternating intervals can differ by one cycle, the average bit period can be a half-integer number of clock cycles. Software can derive all three from one divider D. The start interval is floor(D/4), the odd interval is floor(D/2), and the even interval is D minus the odd interval. Each is written as its value minus one. With these settings one bit lasts D/2 cycles and the first capture lands in the middle of the start bit.

The line input is chosen between the external pin and the local sync transmitter's output (loop-back). It then passes through a two-flop synchroniser. Each frame contains the following, in order:

- one start bit (low)
- 24 data bits, least significant bit first
- one even-parity bit
- one stop bit (high)

A complete frame produces a one-cycle valid strobe together with the payload and an error flag. The receiver is switched on by either of two enable inputs. The two inputs are merged, so setting either one enables the receiver.

Top module: `sync_rx_frac`

## Requirements
- R1: While reset is active and after its release, rx_valid and rx_err are 0 and rx_data is 0, until the first frame completes.
- R2: With cfg_loopback = 1 the receiver takes its line from tx_loop and ignores rx_pin. With cfg_loopback = 0 it takes the line from rx_pin and ignores tx_loop.
- R3: The receiver is enabled when cfg_en_rise or cfg_en_fall is 1. While both are 0, no frame is started and a frame in progress is abandoned with no strobe. A disable that falls in the cycle of the stop capture suppresses that strobe.
- R4: A start edge is a high-to-low transition of the synchronised line while idle. The synchronised line lags the input by two clock edges. The first capture checks the start level. It takes place cfg_start_m1 + 1 cycles after the edge is seen and samples the input as it was cfg_start_m1 + 1 cycles after the falling edge. If that sample is high, reception is aborted with no strobe.
- R5: Captures are numbered k = 0 (start check) onward. The gap after capture k is cfg_even_m1 + 1 cycles when k is even and cfg_odd_m1 + 1 cycles when k is odd.
- R6: Captures 1 to 24 carry data bits 0 to 23 (LSB first). Capture 25 is the parity bit and capture 26 is the stop bit.
- R7: rx_valid is a single-cycle pulse in the cycle after the stop capture. rx_data changes only together with rx_valid and holds its value between strobes.
- R8: rx_err is 1 exactly in a strobe cycle where the stop bit was 0, or where the count of ones over the 24 data bits plus the parity bit is odd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_pin | input | 1 | External serial line, idle high |
| tx_loop | input | 1 | Output of the local sync transmitter, used in loop-back |
| cfg_loopback | input | 1 | 1 selects tx_loop as the line source |
| cfg_en_rise | input | 1 | Enable (merged with cfg_en_fall) |
| cfg_en_fall | input | 1 | Enable (merged with cfg_en_rise) |
| cfg_start_m1 | input | 8 | Start interval minus one |
| cfg_odd_m1 | input | 8 | Gap after odd captures, minus one |
| cfg_even_m1 | input | 8 | Gap after even captures, minus one |
| rx_data | output | 24 | Last received payload |
| rx_valid | output | 1 | One-cycle frame-complete strobe |
| rx_err | output | 1 | Parity or stop error, only with rx_valid |

## Verification
Two events can fall in the same clock edge: the stop-bit capture that produces the strobe, and the enable being removed. The bench knows the edge on which it drove the start bit, so it computes the stop-capture edge as 2 + start interval + 13·D. It drops both enables just before that edge, one edge earlier, and one edge later. A strobe is expected only in the late case, and the bench counts strobes to judge the result. A second pairing tests the start check against a short low pulse. A pulse whose length equals the start interval must abort. A pulse one cycle longer must yield a frame of all ones with an error flag.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
   typedef enum logic [0:0] {
      RX_IDLE = 1'b0,
      RX_RUN  = 1'b1
   } rx_state_t;
endpackage

// File: rtl/sync_rx_front.sv
module sync_rx_front #(
   parameter int STAGES  = 2,
   parameter bit LOOP_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic loop_in,
   input  logic loop_sel,
   output logic line,
   output logic fall
);
   logic raw;
   logic [STAGES-1:0] sync_q;
   logic prev_q;

   if (LOOP_EN) begin : g_loop
      assign raw = loop_sel ? loop_in : pin;
   end else begin : g_pin_only
      assign raw = pin;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '1;
         prev_q <= 1'b1;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], raw};
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign line = sync_q[STAGES-1];
   assign fall = prev_q & ~line;
endmodule

// File: rtl/sync_rx_timer.sv
module sync_rx_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             tick
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (active && cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign tick = active && (cnt_q == '0);
endmodule

// File: rtl/sync_rx_deframer.sv
module sync_rx_deframer #(
   parameter int DATA_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              capture,
   input  logic              bit_in,
   output logic              at_start,
   output logic              at_stop,
   output logic              idx_odd,
   output logic              par_bad,
   output logic [DATA_W-1:0] payload
);
   localparam int LAST  = DATA_W + 2;
   localparam int IDX_W = $clog2(LAST + 1);
   localparam logic [IDX_W-1:0] LAST_I = IDX_W'(LAST);
   localparam logic [IDX_W-1:0] DLAST_I = IDX_W'(DATA_W);

   logic [IDX_W-1:0]  idx_q;
   logic [DATA_W-1:0] shreg_q;
   logic              par_q;
   logic              in_data;

   assign at_start = (idx_q == '0);
   assign at_stop  = (idx_q == LAST_I);
   assign idx_odd  = idx_q[0];
   assign in_data  = !at_start && (idx_q <= DLAST_I);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q   <= '0;
         shreg_q <= '0;
         par_q   <= 1'b0;
      end else if (clear) begin
         idx_q <= '0;
         par_q <= 1'b0;
      end else if (capture) begin
         idx_q <= idx_q + 1'b1;
         if (in_data)
            shreg_q <= {bit_in, shreg_q[DATA_W-1:1]};
         if (!at_start && !at_stop)
            par_q <= par_q ^ bit_in;
      end
   end

   assign par_bad = par_q;
   assign payload = shreg_q;
endmodule

// File: rtl/sync_rx_frac.sv
module sync_rx_frac #(
   parameter int DATA_W      = 24,
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit LOOP_EN     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_pin,
   input  logic              tx_loop,
   input  logic              cfg_loopback,
   input  logic              cfg_en_rise,
   input  logic              cfg_en_fall,
   input  logic [CNT_W-1:0]  cfg_start_m1,
   input  logic [CNT_W-1:0]  cfg_odd_m1,
   input  logic [CNT_W-1:0]  cfg_even_m1,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              rx_err
);
   import sync_rx_pkg::*;

   if (DATA_W < 2) begin : g_bad_data_w
      $error("sync_rx_frac: DATA_W must be at least 2");
   end
   if (CNT_W < 2) begin : g_bad_cnt_w
      $error("sync_rx_frac: CNT_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("sync_rx_frac: SYNC_STAGES must be at least 2");
   end

   rx_state_t         state_q;
   logic              en, line, fall, tick;
   logic              start, abort_rx, finish, load;
   logic [CNT_W-1:0]  load_val;
   logic              at_start, at_stop, idx_odd, par_bad;
   logic [DATA_W-1:0] payload;

   assign en = cfg_en_rise | cfg_en_fall;

   sync_rx_front #(.STAGES(SYNC_STAGES), .LOOP_EN(LOOP_EN)) u_front (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin      (rx_pin),
      .loop_in  (tx_loop),
      .loop_sel (cfg_loopback),
      .line     (line),
      .fall     (fall)
   );

   assign start    = (state_q == RX_IDLE) && fall && en;
   assign abort_rx = tick && at_start && line;
   assign finish   = tick && at_stop;
   assign load     = start || (tick && !at_stop && !abort_rx);
   assign load_val = start   ? cfg_start_m1 :
                     idx_odd ? cfg_odd_m1   : cfg_even_m1;

   sync_rx_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (state_q == RX_RUN),
      .load     (load),
      .load_val (load_val),
      .tick     (tick)
   );

   sync_rx_deframer #(.DATA_W(DATA_W)) u_deframer (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (start),
      .capture  (tick),
      .bit_in   (line),
      .at_start (at_start),
      .at_stop  (at_stop),
      .idx_odd  (idx_odd),
      .par_bad  (par_bad),
      .payload  (payload)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= RX_IDLE;
         rx_valid <= 1'b0;
         rx_err   <= 1'b0;
         rx_data  <= '0;
      end else begin
         rx_valid <= en && finish;
         rx_err   <= en && finish && (!line || par_bad);
         if (en && finish)
            rx_data <= payload;
         if (!en)
            state_q <= RX_IDLE;
         else if (start)
            state_q <= RX_RUN;
         else if (abort_rx || finish)
            state_q <= RX_IDLE;
      end
   end
endmodule

// File: rtl/sync_rx_frac_chk.sv
module sync_rx_frac_chk #(
   parameter int DATA_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_en_rise,
   input logic              cfg_en_fall,
   input logic [DATA_W-1:0] rx_data,
   input logic              rx_valid,
   input logic              rx_err
);
   // R7: strobe lasts one cycle
   p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   // R7: payload only moves with the strobe
   p_data_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |-> $stable(rx_data));

   // R8: error flag never without strobe
   p_err_with_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_err |-> rx_valid);

   // R3: no strobe after a disabled edge
   p_disabled_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_en_rise || cfg_en_fall) |=> !rx_valid);
endmodule

bind sync_rx_frac sync_rx_frac_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sync_rx_frac_bench.sv
`timescale 1ns/1ps
module sync_rx_frac_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_pin = 1'b1;
   logic        tx_loop = 1'b1;
   logic        cfg_loopback = 1'b0;
   logic        cfg_en_rise = 1'b1;
   logic        cfg_en_fall = 1'b1;
   logic [7:0]  cfg_start_m1 = 8'd1;
   logic [7:0]  cfg_odd_m1 = 8'd3;
   logic [7:0]  cfg_even_m1 = 8'd3;
   logic [23:0] rx_data;
   logic        rx_valid;
   logic        rx_err;

   int total = 0;
   int bad = 0;
   int vcnt = 0;
   logic [23:0] vdata;
   logic        verr;
   bit          use_loop = 1'b0;
   bit          finished = 1'b0;

   always #2.5 clk = ~clk;

   sync_rx_frac u_sync_rx_frac (
      .clk(clk), .rst_n(rst_n), .rx_pin(rx_pin), .tx_loop(tx_loop),
      .cfg_loopback(cfg_loopback), .cfg_en_rise(cfg_en_rise),
      .cfg_en_fall(cfg_en_fall), .cfg_start_m1(cfg_start_m1),
      .cfg_odd_m1(cfg_odd_m1), .cfg_even_m1(cfg_even_m1),
      .rx_data(rx_data), .rx_valid(rx_valid), .rx_err(rx_err)
   );

   always @(negedge clk) begin
      if (rx_valid) begin
         vcnt  <= vcnt + 1;
         vdata <= rx_data;
         verr  <= rx_err;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic set_div(input int d);
      cfg_start_m1 = 8'(d / 4 - 1);
      cfg_odd_m1   = 8'(d / 2 - 1);
      cfg_even_m1  = 8'(d - d / 2 - 1);
   endtask

   task automatic drive(input logic v);
      if (use_loop) tx_loop = v;
      else rx_pin = v;
   endtask

   // driven from a negedge; cycle k of the frame precedes posedge k
   task automatic send_frame(input logic [23:0] d, input int dd, input bit fp,
                             input bit bs, input int dis_at);
      logic [26:0] b;
      int cyc = 0;
      b[0] = 1'b0;
      b[24:1] = d;
      b[25] = (^d) ^ fp;
      b[26] = ~bs;
      for (int j = 0; j < 27; j++) begin
         drive(b[j]);
         for (int t = 0; t < ((j + 1) * dd) / 2 - (j * dd) / 2; t++) begin
            @(negedge clk);
            cyc++;
            if (cyc == dis_at) begin
               cfg_en_rise = 1'b0;
               cfg_en_fall = 1'b0;
            end
         end
      end
      drive(1'b1);
      repeat (6) @(negedge clk);
   endtask

   task automatic expect_frame(input string req, input logic [23:0] d,
                               input int dd, input bit fp, input bit bs);
      int c0 = vcnt;
      set_div(dd);
      send_frame(d, dd, fp, bs, -1);
      chk(vcnt == c0 + 1, req, "strobe count", 32'(vcnt - c0), 32'd1);
      chk(vdata == d, req, "payload", {8'd0, vdata}, {8'd0, d});
      chk(verr == (fp | bs), req, "error flag", {31'd0, verr}, {31'd0, fp | bs});
   endtask

   task automatic expect_none(input string req, input string what, input int c0);
      chk(vcnt == c0, req, what, 32'(vcnt - c0), 32'd0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int c0;
      int off;
      int dd;
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      chk(rx_valid == 1'b0 && rx_err == 1'b0, "R1", "outputs in reset",
          {30'd0, rx_valid, rx_err}, 32'd0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(rx_valid == 1'b0 && rx_err == 1'b0 && rx_data == 24'd0, "R1",
          "outputs after reset", {7'd0, rx_valid, rx_data}, 32'd0);

      // R5 R6: directed dividers, even and odd, smallest and largest
      expect_frame("R6", 24'hA5C30F, 8, 1'b0, 1'b0);
      expect_frame("R5", 24'h000001, 9, 1'b0, 1'b0);
      expect_frame("R5", 24'h800000, 63, 1'b0, 1'b0);
      expect_frame("R5", 24'h5A5A5A, 511, 1'b0, 1'b0);

      // R5 R6: random payloads and dividers
      for (int i = 0; i < 30; i++) begin
         expect_frame("R6", 24'($urandom), 8 + int'($urandom % 33), 1'b0, 1'b0);
         repeat (int'($urandom % 5)) @(negedge clk);
      end

      // R8: error causes
      expect_frame("R8", 24'h123456, 12, 1'b1, 1'b0);
      expect_frame("R8", 24'hFEDCBA, 13, 1'b0, 1'b1);
      expect_frame("R8", 24'h000000, 10, 1'b1, 1'b1);

      // R4: short low pulse of start-interval length aborts
      dd = 16; off = dd / 4; set_div(dd);
      c0 = vcnt;
      drive(1'b0); repeat (off) @(negedge clk); drive(1'b1);
      repeat (15 * dd) @(negedge clk);
      expect_none("R4", "glitch strobe", c0);
      // R4: one cycle longer passes the start check, all-ones frame, parity bad
      c0 = vcnt;
      drive(1'b0); repeat (off + 1) @(negedge clk); drive(1'b1);
      repeat (15 * dd) @(negedge clk);
      chk(vcnt == c0 + 1, "R4", "long pulse strobe", 32'(vcnt - c0), 32'd1);
      chk(vdata == 24'hFFFFFF && verr == 1'b1, "R4", "long pulse result",
          {7'd0, verr, vdata}, {7'd0, 1'b1, 24'hFFFFFF});

      // R2: loop-back source, pin held low and ignored
      cfg_loopback = 1'b1; use_loop = 1'b1; rx_pin = 1'b0;
      repeat (4) @(negedge clk);
      expect_frame("R2", 24'h3C3C3C, 10, 1'b0, 1'b0);
      rx_pin = 1'b1; use_loop = 1'b0;
      repeat (4) @(negedge clk);
      c0 = vcnt; set_div(10);
      send_frame(24'h111111, 10, 1'b0, 1'b0, -1);
      expect_none("R2", "pin used in loop-back", c0);
      cfg_loopback = 1'b0;
      c0 = vcnt; use_loop = 1'b1;
      send_frame(24'h222222, 10, 1'b0, 1'b0, -1);
      use_loop = 1'b0;
      expect_none("R2", "loop used without loop-back", c0);

      // R3: merged enables
      cfg_en_rise = 1'b1; cfg_en_fall = 1'b0;
      expect_frame("R3", 24'h0F0F0F, 11, 1'b0, 1'b0);
      cfg_en_rise = 1'b0; cfg_en_fall = 1'b1;
      expect_frame("R3", 24'hF0F0F0, 11, 1'b0, 1'b0);
      cfg_en_fall = 1'b0;
      c0 = vcnt; send_frame(24'h777777, 11, 1'b0, 1'b0, -1);
      expect_none("R3", "disabled strobe", c0);

      // R3: disable mid-frame abandons it
      cfg_en_rise = 1'b1; cfg_en_fall = 1'b1;
      c0 = vcnt; set_div(12);
      send_frame(24'h999999, 12, 1'b0, 1'b0, 5 * 12);
      expect_none("R3", "abandoned frame", c0);
      cfg_en_rise = 1'b1; cfg_en_fall = 1'b1;
      expect_frame("R3", 24'h246802, 12, 1'b0, 1'b0);

      // R3 R7: disable around the stop-capture edge 2 + off + 13*D
      dd = 14; off = dd / 4; set_div(dd);
      c0 = vcnt;
      send_frame(24'hABCDEF, dd, 1'b0, 1'b0, 1 + off + 13 * dd);
      cfg_en_rise = 1'b1; cfg_en_fall = 1'b1;
      expect_none("R3", "disable one edge early", c0);
      c0 = vcnt;
      send_frame(24'hABCDEF, dd, 1'b0, 1'b0, 2 + off + 13 * dd);
      cfg_en_rise = 1'b1; cfg_en_fall = 1'b1;
      expect_none("R3", "disable on stop edge", c0);
      c0 = vcnt;
      send_frame(24'hABCDEF, dd, 1'b0, 1'b0, 3 + off + 13 * dd);
      cfg_en_rise = 1'b1; cfg_en_fall = 1'b1;
      chk(vcnt == c0 + 1, "R7", "disable after stop edge", 32'(vcnt - c0), 32'd1);
      chk(vdata == 24'hABCDEF, "R7", "payload held", {8'd0, rx_data}, {8'd0, 24'hABCDEF});

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule